// File: doc/BRIEF.md
# Cascaded Biquad Parametric Equalizer

This block equalizes a multi-channel audio stream. A sample enters on a valid/ready port together with a channel number. It is scaled by a pre-gain, then filtered by a chain of second-order IIR sections, then scaled by a post-gain. Each multiplying stage is followed by its own arithmetic right shift and by saturation to the signed 32-bit range. The coefficients and shift amounts for each channel are fetched through two read ports with no read latency. The filter history of every channel and section is kept in registers inside the block.

A single multiply-accumulate unit does all of the arithmetic, one product per clock, and works through the stages in order. The input stays not-ready until the result has been produced. The enable and stage-count settings are captured when a sample is accepted. With the enable clear, the sample is copied to the output on the next cycle. The stage-count field holds the number of active sections minus one. Sections beyond that count are skipped, and their history is left as it is.

Top module: `biquad_eq`

## Requirements
- R1: While reset is active and in the first cycle after it, `in_ready_o` is 1 and `out_valid_o` is 0.
- R2: A sample accepted with `cfg_en_i` = 0 appears unchanged on `out_data_o`, with its channel on `out_chan_o`, while `out_valid_o` is high in the following cycle, and `in_ready_o` stays high.
- R3: The pre-gain stage computes sat(gain[ch*62+0] * x >>> shift[ch*14+0]). The post-gain stage uses gain word ch*62+61 and shift word ch*14+13, and its result is the output.
- R4: Section s reads gain words ch*62+1+5s+t for t = 0..4 as b0, b1, b2, a1, a2. It forms b0*x + b1*x1 + b2*x2 - a1*y1 - a2*y2 in a 64-bit two's-complement accumulator and then shifts right by shift word ch*14+1+s.
- R5: Every shift is arithmetic, by 0 to 31 places, and rounds toward minus infinity.
- R6: The output of every stage saturates to the range [-2^31, 2^31-1] before it is passed on.
- R7: `cfg_stages_i` holds the number of active sections minus one, and values above 11 count as 11. Inactive sections leave the signal untouched and do not update their history.
- R8: Each channel has its own parameter window and its own history. Samples on one channel never alter the results of another channel.
- R9: A sample accepted with the enable set drives `in_ready_o` low from the next cycle. Its result appears 6*N+4 clock edges after the accepting edge, where N is the number of active sections. `out_valid_o` is high for one cycle, `in_ready_o` returns high in that same cycle, and results leave in the order the samples were accepted.
- R10: Reset clears the history (x1, x2, y1, y2) of every channel and section to zero.
- R11: A section with coefficients (1, 0, 0, 0, 0) and shift 0 passes its input through unchanged.
- R12: The enable and stage count are sampled only on the accepting edge. Changes while a sample is being processed have no effect on that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Equalizer enable; 0 selects pass-through |
| cfg_stages_i | input | 4 | Active section count minus one |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Block can accept a sample |
| in_chan_i | input | 3 | Channel of the input sample |
| in_data_i | input | 32 | Signed input sample |
| out_valid_o | output | 1 | Result valid, one cycle per sample |
| out_chan_o | output | 3 | Channel of the result |
| out_data_o | output | 32 | Signed result |
| gain_addr_o | output | 9 | Gain parameter word address |
| gain_rdata_i | input | 32 | Gain word at `gain_addr_o`, same cycle |
| shift_addr_o | output | 7 | Shift parameter word address |
| shift_rdata_i | input | 5 | Shift amount at `shift_addr_o`, same cycle |

## Verification
A fault in the stage sequencer or the ready logic shows at the ports within one sample. The result arrives on the wrong edge or `in_ready_o` disagrees with the model, and the per-clock comparison reports it in that cycle. A fault in the filter history is invisible on the sample that writes it. It shows only on the next sample of the same channel and section. For that reason the delay-line and skipped-section cases send a second sample on purpose, and the random phase revisits every channel many times. Arithmetic faults in the shifts and saturation are exposed by hand-computed negative values and overflow values.

// File: rtl/biquad_eq_pkg.sv
package biquad_eq_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_MAC, SEQ_COMMIT} seq_state_e;
  typedef enum logic [1:0] {STG_PRE, STG_SEC, STG_POST} stage_kind_e;
  localparam int TERMS_PER_SEC = 5;
endpackage

// File: rtl/biquad_eq_ctrl.sv
module biquad_eq_ctrl
  import biquad_eq_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int NSEC  = 12,
  parameter int CFG_W = 4,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SEC_W = (NSEC > 1) ? $clog2(NSEC) : 1,
  localparam int GPC   = TERMS_PER_SEC * NSEC + 2,
  localparam int SPC   = NSEC + 2,
  localparam int GA_W  = $clog2(NCH * GPC),
  localparam int SA_W  = $clog2(NCH * SPC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              cfg_en_i,
  input  logic [CFG_W-1:0]  cfg_stages_i,
  input  logic [CH_W-1:0]   in_chan_i,
  output logic              in_ready_o,
  output logic              load_o,
  output logic              bypass_o,
  output logic              mac_o,
  output logic              commit_o,
  output logic              done_o,
  output logic              first_o,
  output logic              neg_o,
  output stage_kind_e       kind_o,
  output logic [CH_W-1:0]   ch_o,
  output logic [SEC_W-1:0]  sec_o,
  output logic [2:0]        term_o,
  output logic [GA_W-1:0]   gain_addr_o,
  output logic [SA_W-1:0]   shift_addr_o
);
  seq_state_e       st_q;
  stage_kind_e      kind_q;
  logic [CH_W-1:0]  ch_q;
  logic [SEC_W-1:0] sec_q, last_sec_q, last_sec_in;
  logic [2:0]       term_q, last_term;
  logic             accept;
  int               g_off, s_off;

  assign in_ready_o = (st_q == SEQ_IDLE);
  assign accept     = in_valid_i && in_ready_o;
  assign load_o     = accept && cfg_en_i;
  assign bypass_o   = accept && !cfg_en_i;
  assign mac_o      = (st_q == SEQ_MAC);
  assign commit_o   = (st_q == SEQ_COMMIT);
  assign done_o     = commit_o && (kind_q == STG_POST);
  assign first_o    = (term_q == 3'd0);
  assign neg_o      = (kind_q == STG_SEC) && (term_q >= 3'd3);
  assign last_term  = (kind_q == STG_SEC) ? 3'(TERMS_PER_SEC - 1) : 3'd0;
  assign kind_o     = kind_q;
  assign ch_o       = ch_q;
  assign sec_o      = sec_q;
  assign term_o     = term_q;

  // clamp count field to the implemented section count
  always_comb begin
    if (int'(cfg_stages_i) >= NSEC) last_sec_in = SEC_W'(NSEC - 1);
    else                            last_sec_in = SEC_W'(cfg_stages_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= SEQ_IDLE;
      kind_q     <= STG_PRE;
      ch_q       <= '0;
      sec_q      <= '0;
      last_sec_q <= '0;
      term_q     <= '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: begin
          if (accept) ch_q <= in_chan_i;
          if (load_o) begin
            st_q       <= SEQ_MAC;
            kind_q     <= STG_PRE;
            sec_q      <= '0;
            term_q     <= '0;
            last_sec_q <= last_sec_in;
          end
        end
        SEQ_MAC: begin
          if (term_q == last_term) st_q <= SEQ_COMMIT;
          else                     term_q <= term_q + 3'd1;
        end
        SEQ_COMMIT: begin
          term_q <= '0;
          unique case (kind_q)
            STG_PRE: begin
              kind_q <= STG_SEC;
              sec_q  <= '0;
              st_q   <= SEQ_MAC;
            end
            STG_SEC: begin
              if (sec_q == last_sec_q) kind_q <= STG_POST;
              else                     sec_q  <= sec_q + 1'b1;
              st_q <= SEQ_MAC;
            end
            default: st_q <= SEQ_IDLE;
          endcase
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (kind_q)
      STG_PRE: begin
        g_off = 0;
        s_off = 0;
      end
      STG_SEC: begin
        g_off = 1 + TERMS_PER_SEC * int'(sec_q) + int'(term_q);
        s_off = 1 + int'(sec_q);
      end
      default: begin
        g_off = GPC - 1;
        s_off = SPC - 1;
      end
    endcase
    gain_addr_o  = GA_W'(int'(ch_q) * GPC + g_off);
    shift_addr_o = SA_W'(int'(ch_q) * SPC + s_off);
  end
endmodule

// File: rtl/biquad_eq_state.sv
module biquad_eq_state #(
  parameter int NCH  = 8,
  parameter int NSEC = 12,
  parameter int DW   = 32,
  localparam int NROW  = NCH * NSEC,
  localparam int IDX_W = (NROW > 1) ? $clog2(NROW) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic                 we_i,
  input  logic signed [DW-1:0] x_new_i,
  input  logic signed [DW-1:0] y_new_i,
  output logic signed [DW-1:0] x1_o,
  output logic signed [DW-1:0] x2_o,
  output logic signed [DW-1:0] y1_o,
  output logic signed [DW-1:0] y2_o
);
  logic signed [DW-1:0] x1_q [NROW];
  logic signed [DW-1:0] x2_q [NROW];
  logic signed [DW-1:0] y1_q [NROW];
  logic signed [DW-1:0] y2_q [NROW];

  assign x1_o = x1_q[idx_i];
  assign x2_o = x2_q[idx_i];
  assign y1_o = y1_q[idx_i];
  assign y2_o = y2_q[idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NROW; i++) begin
        x1_q[i] <= '0;
        x2_q[i] <= '0;
        y1_q[i] <= '0;
        y2_q[i] <= '0;
      end
    end else if (we_i) begin
      x2_q[idx_i] <= x1_q[idx_i];
      x1_q[idx_i] <= x_new_i;
      y2_q[idx_i] <= y1_q[idx_i];
      y1_q[idx_i] <= y_new_i;
    end
  end
endmodule

// File: rtl/biquad_eq_dp.sv
module biquad_eq_dp #(
  parameter int DW   = 32,
  parameter int SH_W = 5,
  localparam int AW  = 2 * DW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic signed [DW-1:0] load_data_i,
  input  logic                 mac_i,
  input  logic                 first_i,
  input  logic                 neg_i,
  input  logic signed [DW-1:0] coef_i,
  input  logic signed [DW-1:0] operand_i,
  input  logic                 commit_i,
  input  logic [SH_W-1:0]      shift_i,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] result_o
);
  localparam logic signed [AW-1:0] MAX_V = AW'({1'b0, {(DW-1){1'b1}}});
  localparam logic signed [AW-1:0] MIN_V = -MAX_V - AW'(1);

  logic signed [AW-1:0] acc_q, coef_w, op_w, prod, addend, base, shifted;
  logic signed [DW-1:0] x_q;

  assign coef_w  = AW'(coef_i);
  assign op_w    = AW'(operand_i);
  assign prod    = coef_w * op_w;
  assign addend  = neg_i ? -prod : prod;
  assign base    = first_i ? '0 : acc_q;
  assign shifted = acc_q >>> shift_i;
  assign x_o     = x_q;

  always_comb begin
    if (shifted > MAX_V)      result_o = MAX_V[DW-1:0];
    else if (shifted < MIN_V) result_o = MIN_V[DW-1:0];
    else                      result_o = shifted[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      x_q   <= '0;
    end else begin
      if (mac_i) acc_q <= base + addend;
      if (load_i)        x_q <= load_data_i;
      else if (commit_i) x_q <= result_o;
    end
  end
endmodule

// File: rtl/biquad_eq.sv
module biquad_eq
  import biquad_eq_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int NSEC  = 12,
  parameter int DW    = 32,
  parameter int SH_W  = 5,
  parameter int CFG_W = 4,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SEC_W = (NSEC > 1) ? $clog2(NSEC) : 1,
  localparam int GPC   = TERMS_PER_SEC * NSEC + 2,
  localparam int SPC   = NSEC + 2,
  localparam int GA_W  = $clog2(NCH * GPC),
  localparam int SA_W  = $clog2(NCH * SPC),
  localparam int NROW  = NCH * NSEC,
  localparam int IDX_W = (NROW > 1) ? $clog2(NROW) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic [CFG_W-1:0] cfg_stages_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [CH_W-1:0]  in_chan_i,
  input  logic [DW-1:0]    in_data_i,
  output logic             out_valid_o,
  output logic [CH_W-1:0]  out_chan_o,
  output logic [DW-1:0]    out_data_o,
  output logic [GA_W-1:0]  gain_addr_o,
  input  logic [DW-1:0]    gain_rdata_i,
  output logic [SA_W-1:0]  shift_addr_o,
  input  logic [SH_W-1:0]  shift_rdata_i
);
  logic                 load, bypass, mac, commit, done, first, neg;
  stage_kind_e          kind;
  logic [CH_W-1:0]      ch;
  logic [SEC_W-1:0]     sec;
  logic [2:0]           term;
  logic [IDX_W-1:0]     row;
  logic signed [DW-1:0] x_cur, result, operand, x1, x2, y1, y2;
  logic                 out_valid_q;
  logic [CH_W-1:0]      out_chan_q;
  logic [DW-1:0]        out_data_q;

  biquad_eq_ctrl #(.NCH(NCH), .NSEC(NSEC), .CFG_W(CFG_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .cfg_en_i    (cfg_en_i),
    .cfg_stages_i(cfg_stages_i),
    .in_chan_i   (in_chan_i),
    .in_ready_o  (in_ready_o),
    .load_o      (load),
    .bypass_o    (bypass),
    .mac_o       (mac),
    .commit_o    (commit),
    .done_o      (done),
    .first_o     (first),
    .neg_o       (neg),
    .kind_o      (kind),
    .ch_o        (ch),
    .sec_o       (sec),
    .term_o      (term),
    .gain_addr_o (gain_addr_o),
    .shift_addr_o(shift_addr_o)
  );

  assign row = IDX_W'(int'(ch) * NSEC + int'(sec));

  biquad_eq_state #(.NCH(NCH), .NSEC(NSEC), .DW(DW)) i_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idx_i  (row),
    .we_i   (commit && (kind == STG_SEC)),
    .x_new_i(x_cur),
    .y_new_i(result),
    .x1_o   (x1),
    .x2_o   (x2),
    .y1_o   (y1),
    .y2_o   (y2)
  );

  // term order inside a section: b0*x, b1*x1, b2*x2, a1*y1, a2*y2
  always_comb begin
    unique case (term)
      3'd1:    operand = x1;
      3'd2:    operand = x2;
      3'd3:    operand = y1;
      3'd4:    operand = y2;
      default: operand = x_cur;
    endcase
  end

  biquad_eq_dp #(.DW(DW), .SH_W(SH_W)) i_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_data_i(in_data_i),
    .mac_i      (mac),
    .first_i    (first),
    .neg_i      (neg),
    .coef_i     (gain_rdata_i),
    .operand_i  (operand),
    .commit_i   (commit),
    .shift_i    (shift_rdata_i),
    .x_o        (x_cur),
    .result_o   (result)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_chan_q  <= '0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= bypass || done;
      if (bypass) begin
        out_chan_q <= in_chan_i;
        out_data_q <= in_data_i;
      end else if (done) begin
        out_chan_q <= ch;
        out_data_q <= result;
      end
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_chan_o  = out_chan_q;
  assign out_data_o  = out_data_q;
endmodule

// File: rtl/biquad_eq_chk.sv
module biquad_eq_chk #(
  parameter int NCH   = 8,
  parameter int NSEC  = 12,
  parameter int DW    = 32,
  parameter int SH_W  = 5,
  parameter int CFG_W = 4,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int GPC  = 5 * NSEC + 2,
  localparam int SPC  = NSEC + 2,
  localparam int GA_W = $clog2(NCH * GPC),
  localparam int SA_W = $clog2(NCH * SPC)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_en_i,
  input logic [CFG_W-1:0] cfg_stages_i,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [CH_W-1:0]  in_chan_i,
  input logic [DW-1:0]    in_data_i,
  input logic             out_valid_o,
  input logic [CH_W-1:0]  out_chan_o,
  input logic [DW-1:0]    out_data_o,
  input logic [GA_W-1:0]  gain_addr_o,
  input logic [DW-1:0]    gain_rdata_i,
  input logic [SA_W-1:0]  shift_addr_o,
  input logic [SH_W-1:0]  shift_rdata_i
);
  p_busy_after_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && cfg_en_i) |=> !in_ready_o);

  p_bypass_copy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && !cfg_en_i) |=>
      (out_valid_o && in_ready_o && out_data_o == $past(in_data_i) && out_chan_o == $past(in_chan_i)));

  p_out_when_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> in_ready_o);

  p_no_spurious_out_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && !(in_valid_i && !cfg_en_i)) |=> !out_valid_o);

  p_gain_addr_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> (int'(gain_addr_o) < NCH * GPC));

  p_shift_addr_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> (int'(shift_addr_o) < NCH * SPC));
endmodule

bind biquad_eq biquad_eq_chk #(
  .NCH(NCH), .NSEC(NSEC), .DW(DW), .SH_W(SH_W), .CFG_W(CFG_W)
) i_biquad_eq_chk (.*);

// File: tb/test_biquad_eq.sv
module test_biquad_eq;
  localparam int NCH  = 8;
  localparam int NSEC = 12;
  localparam int GPC  = 5 * NSEC + 2;
  localparam int SPC  = NSEC + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0;
  logic [3:0]  cfg_m1 = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_chan = '0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [2:0]  out_chan;
  logic [31:0] out_data;
  logic [8:0]  gain_addr;
  logic [31:0] gain_rdata;
  logic [6:0]  shift_addr;
  logic [4:0]  shift_rdata;

  logic signed [31:0] gmem [NCH*GPC];
  logic [4:0]         smem [NCH*SPC];

  always #5 clk = ~clk;

  assign gain_rdata  = (int'(gain_addr) < NCH*GPC) ? gmem[gain_addr] : '0;
  assign shift_rdata = (int'(shift_addr) < NCH*SPC) ? smem[shift_addr] : '0;

  biquad_eq i_biquad_eq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_stages_i(cfg_m1),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_chan_i(in_chan), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_chan_o(out_chan), .out_data_o(out_data),
    .gain_addr_o(gain_addr), .gain_rdata_i(gain_rdata),
    .shift_addr_o(shift_addr), .shift_rdata_i(shift_rdata)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_req  = "R9";
  bit    cmp_on   = 1'b0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  // ---------------- behavioural reference model ----------------
  int m_x1 [NCH*NSEC];
  int m_x2 [NCH*NSEC];
  int m_y1 [NCH*NSEC];
  int m_y2 [NCH*NSEC];
  int m_cnt = 0, m_data = 0, m_chan = 0, m_pend = 0, m_pchan = 0;
  bit m_valid = 1'b0;

  function automatic int sat(input longint v);
    if (v > 64'sd2147483647) return 32'sh7fffffff;
    if (v < -64'sd2147483648) return 32'sh80000000;
    return int'(v);
  endfunction

  function automatic int gw(input int a);
    return int'(gmem[a]);
  endfunction

  function automatic int model(input int ch, input int x, input int m1);
    longint acc;
    int v, gb, sb, c, r, y;
    gb = ch * GPC;
    sb = ch * SPC;
    if (m1 > NSEC - 1) m1 = NSEC - 1;
    acc = longint'(gw(gb)) * longint'(x);
    v = sat(acc >>> smem[sb]);
    for (int s = 0; s <= m1; s++) begin
      r = ch * NSEC + s;
      c = gb + 1 + 5 * s;
      acc = longint'(gw(c)) * v + longint'(gw(c+1)) * m_x1[r] + longint'(gw(c+2)) * m_x2[r]
          - longint'(gw(c+3)) * m_y1[r] - longint'(gw(c+4)) * m_y2[r];
      y = sat(acc >>> smem[sb + 1 + s]);
      m_x2[r] = m_x1[r]; m_x1[r] = v;
      m_y2[r] = m_y1[r]; m_y1[r] = y;
      v = y;
    end
    acc = longint'(gw(gb + GPC - 1)) * longint'(v);
    return sat(acc >>> smem[sb + SPC - 1]);
  endfunction

  always @(posedge clk) begin
    bit fire, nv;
    if (!rst_n) begin
      for (int i = 0; i < NCH*NSEC; i++) begin
        m_x1[i] = 0; m_x2[i] = 0; m_y1[i] = 0; m_y2[i] = 0;
      end
      m_cnt = 0; m_valid = 1'b0;
    end else begin
      fire = in_valid && (m_cnt == 0);
      nv = 1'b0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin nv = 1'b1; m_data = m_pend; m_chan = m_pchan; end
      end
      if (fire) begin
        if (!cfg_en) begin
          nv = 1'b1; m_data = int'(in_data); m_chan = int'(in_chan);
        end else begin
          m_pend  = model(int'(in_chan), int'(in_data), int'(cfg_m1));
          m_pchan = int'(in_chan);
          m_cnt   = 6 * ((int'(cfg_m1) > NSEC-1 ? NSEC-1 : int'(cfg_m1)) + 1) + 4;
        end
      end
      m_valid = nv;
    end
  end

  // per-clock comparison (R9 timing, R12 capture, data of the running phase)
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(cur_req, "in_ready", in_ready, m_cnt == 0);
      chk(cur_req, "out_valid", out_valid, m_valid);
      if (m_valid) begin
        chk(cur_req, "out_data", longint'(signed'(out_data)), m_data);
        chk(cur_req, "out_chan", out_chan, m_chan);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic set_identity(input int ch);
    gmem[ch*GPC] = 1;
    gmem[ch*GPC + GPC - 1] = 1;
    smem[ch*SPC] = 0;
    smem[ch*SPC + SPC - 1] = 0;
    for (int s = 0; s < NSEC; s++) begin
      gmem[ch*GPC + 1 + 5*s] = 1;
      for (int t = 1; t < 5; t++) gmem[ch*GPC + 1 + 5*s + t] = 0;
      smem[ch*SPC + 1 + s] = 0;
    end
  endtask

  task automatic set_sec(input int ch, input int s, input int b0, input int b1,
                         input int b2, input int a1, input int a2);
    gmem[ch*GPC + 1 + 5*s]     = b0;
    gmem[ch*GPC + 1 + 5*s + 1] = b1;
    gmem[ch*GPC + 1 + 5*s + 2] = b2;
    gmem[ch*GPC + 1 + 5*s + 3] = a1;
    gmem[ch*GPC + 1 + 5*s + 4] = a2;
  endtask

  task automatic send(input int ch, input int x, input bit en, input int m1, output int y);
    @(negedge clk);
    in_chan = 3'(ch); in_data = x; cfg_en = en; cfg_m1 = 4'(m1); in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    y = int'(out_data);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int y;
    for (int c = 0; c < NCH; c++) set_identity(c);
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "in_ready in reset", in_ready, 1);
    chk("R1", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "in_ready after reset", in_ready, 1);
    chk("R1", "out_valid after reset", out_valid, 0);
    cmp_on = 1'b1;

    // R2: pass-through with enable clear
    cur_req = "R2";
    send(1, -12345, 1'b0, 3, y);
    chk("R2", "bypass data", y, -12345);
    chk("R2", "bypass chan", out_chan, 1);

    // R11: all sections identity
    cur_req = "R11";
    send(0, 777, 1'b1, 11, y);
    chk("R11", "identity chain", y, 777);

    // R3, R5: pre/post gain with arithmetic shift
    cur_req = "R3";
    gmem[2*GPC] = 3;  smem[2*SPC] = 1;
    gmem[2*GPC + GPC - 1] = 5; smem[2*SPC + SPC - 1] = 2;
    send(2, 100, 1'b1, 0, y);
    chk("R3", "pre/post gain", y, 187);
    cur_req = "R5";
    send(2, -100, 1'b1, 0, y);
    chk("R5", "negative shift floors", y, -188);

    // R6: saturation in the pre stage
    cur_req = "R6";
    gmem[3*GPC] = 32'sh40000000;
    send(3, 8, 1'b1, 0, y);
    chk("R6", "positive clamp", y, 32'sh7fffffff);
    send(3, -8, 1'b1, 0, y);
    chk("R6", "negative clamp", y, 32'sh80000000);

    // R4, R10: delay terms and subtracted feedback on channel 4
    cur_req = "R4";
    set_sec(4, 0, 0, 1, 0, 0, 0);
    send(4, 10, 1'b1, 0, y);
    chk("R10", "history starts at zero", y, 0);
    send(4, 20, 1'b1, 0, y);
    chk("R4", "b1 uses x1", y, 10);
    set_sec(4, 0, 0, 0, 1, 0, 0);
    send(4, 30, 1'b1, 0, y);
    chk("R4", "b2 uses x2", y, 10);
    set_sec(4, 0, 0, 0, 0, 2, 0);
    send(4, 40, 1'b1, 0, y);
    chk("R4", "a1 term subtracted", y, -20);
    set_sec(4, 0, 0, 0, 0, 0, 1);
    send(4, 50, 1'b1, 0, y);
    chk("R4", "a2 term subtracted", y, -10);

    // R7: skipped section keeps its history
    cur_req = "R7";
    set_sec(5, 1, 0, 0, 0, 0, 0);
    send(5, 55, 1'b1, 0, y);
    chk("R7", "inactive section bypassed", y, 55);
    set_sec(5, 1, 0, 1, 0, 0, 0);
    send(5, 66, 1'b1, 1, y);
    chk("R7", "skipped section history untouched", y, 0);
    send(5, 77, 1'b1, 1, y);
    chk("R7", "section now active", y, 66);

    // R8: independent channels
    cur_req = "R8";
    set_sec(6, 0, 0, 1, 0, 0, 0);
    set_sec(7, 0, 0, 1, 0, 0, 0);
    send(6, 100, 1'b1, 0, y);
    send(7, 200, 1'b1, 0, y);
    send(6, 300, 1'b1, 0, y);
    chk("R8", "channel 6 history", y, 100);
    send(7, 400, 1'b1, 0, y);
    chk("R8", "channel 7 history", y, 200);

    // R10: reset clears history
    cmp_on = 1'b0;
    do_reset();
    cmp_on = 1'b1;
    cur_req = "R10";
    send(6, 500, 1'b1, 0, y);
    chk("R10", "history cleared by reset", y, 0);

    // R9, R12: random traffic, back-to-back, config changes while busy
    cur_req = "R12";
    for (int i = 0; i < NCH*GPC; i++) gmem[i] = $urandom;
    for (int i = 0; i < NCH*SPC; i++) smem[i] = 5'($urandom);
    for (int c = 0; c < 4; c++) begin
      gmem[c*GPC] = 32'sh00800000;
      smem[c*SPC] = 23;
      gmem[c*GPC + GPC - 1] = 32'sh10000000;
      smem[c*SPC + SPC - 1] = 28;
      for (int s = 0; s < NSEC; s++) smem[c*SPC + 1 + s] = 30;
    end
    @(negedge clk);
    for (int i = 0; i < 300; i++) begin
      in_chan = 3'($urandom);
      in_data = $urandom;
      cfg_en = ($urandom % 4) != 0;
      cfg_m1 = 4'($urandom);
      in_valid = ($urandom % 5) != 0;
      while (in_valid && !in_ready) begin
        @(negedge clk);
        if (!in_ready) begin
          cfg_en = ($urandom % 4) != 0;
          cfg_m1 = 4'($urandom);
        end
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (100) @(negedge clk);

    summary();
    $finish;
  end
endmodule